// File: doc/BRIEF.md
# Keyboard Controller Host Mailbox

This block is the byte-wide mailbox that sits between a host bus and the small microcontroller inside a keyboard controller. The host deposits a byte into the inbound buffer. The host chooses either its data address or its command address for the write, and the choice is recorded in a command/data flag. The local CPU deposits a byte into the outbound buffer for the host to collect. Two full flags track both buffers. The host side only ever reads the full flags. The local CPU clears them by consuming data, and the host does the same.

Each side has single-cycle read and write strobes and one select line. On the host side the select line chooses between the data port and the command/status port. On the CPU side it chooses between the data port and the status register. The block drives an interrupt request toward the host while outbound data waits, gated by an enable input. It also drives an interrupt toward the local CPU while inbound data waits. The local CPU may set the status bits that carry no flag to any value, for its own protocol use.

Top module: `kbc_mailbox`

## Requirements
- R1: A synchronous reset clears the status register, both read-data outputs, `kirq` and `ibf_irq` to zero by the edge after it is sampled.
- R2: A host write loads `host_wdata` into the inbound buffer and sets the input-full flag. `ibf_irq` is 1 from the following edge while that flag is set.
- R3: On every host write the command/data flag takes the value of `host_sel`: 1 marks a command, 0 marks data.
- R4: A CPU read with `cpu_sel`=0 returns the inbound buffer on `cpu_rdata` and clears the input-full flag, so `ibf_irq` drops.
- R5: A CPU write with `cpu_sel`=0 loads the outbound buffer and sets the output-full flag. `kirq` is 1 from the same edge when `kirq_en` is 1.
- R6: `kirq` is registered as output-full AND `kirq_en`. With `kirq_en`=0 it stays 0 while the status still reports output-full. It rises at the next edge once `kirq_en` returns to 1.
- R7: A host read with `host_sel`=0 returns the outbound buffer on `host_rdata` and clears the output-full flag and `kirq`.
- R8: The status byte has output-full at bit 0, input-full at bit 1 and command/data at bit 3. A host read with `host_sel`=1 returns it, and a CPU read with `cpu_sel`=1 returns it. Status reads change no flag.
- R9: A CPU write with `cpu_sel`=1 loads bits 2 and 4 to 7 from `cpu_wdata` and leaves bits 0, 1 and 3 alone. The host has no path that writes these bits.
- R10: When a set and a clear of the same full flag coincide, the set wins. The concurrent read still returns the buffer contents from before the edge.
- R11: Each read-data output is registered. It updates at the edge that samples its read strobe and holds its value until the next read on that side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_sel | input | 1 | Host select: 0 data port, 1 command (write) / status (read) |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Host read data, registered |
| kirq | output | 1 | Interrupt to host: outbound data waiting |
| kirq_en | input | 1 | Enable for `kirq` |
| cpu_wr | input | 1 | Local CPU write strobe |
| cpu_rd | input | 1 | Local CPU read strobe |
| cpu_sel | input | 1 | CPU select: 0 data port, 1 status register |
| cpu_wdata | input | DW | CPU write data |
| cpu_rdata | output | DW | CPU read data, registered |
| ibf_irq | output | 1 | Interrupt to local CPU: inbound data waiting |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a host data read together with a CPU data write, which both act on the output-full flag. The second pair is a host write together with a CPU data read, which both act on the input-full flag. The vector table raises both strobes of each pair in one cycle. It then judges two things: that the flag and its interrupt remain set, and that the concurrent read returned the old buffer byte. A later plain read must then return the newly written byte.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int OBF_BIT = 0;
  localparam int IBF_BIT = 1;
  localparam int CD_BIT  = 3;

  // Bits of the status byte that the local CPU owns
  function automatic logic [31:0] user_mask(input int dw);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < dw; i++) begin
      if (i != OBF_BIT && i != IBF_BIT && i != CD_BIT) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/kbc_flag.sv
module kbc_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q,
  output logic nxt
);
  // set has priority over clear
  always_comb begin
    if (set)      nxt = 1'b1;
    else if (clr) nxt = 1'b0;
    else          nxt = q;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= nxt;
  end
endmodule

// File: rtl/kbc_buf.sv
module kbc_buf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/kbc_mailbox.sv
module kbc_mailbox #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic          host_sel,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          kirq,
  input  logic          kirq_en,
  input  logic          cpu_wr,
  input  logic          cpu_rd,
  input  logic          cpu_sel,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          ibf_irq
);
  import kbc_pkg::*;

  localparam logic [DW-1:0] UMASK = DW'(user_mask(DW));

  logic host_dat_rd, cpu_dat_rd, cpu_dat_wr, cpu_stat_wr;
  logic obf_q, obf_nx, ibf_q, ibf_nx;
  logic [0:0] cd_q;
  logic [DW-1:0] ibuf_q, obuf_q, status;

  assign host_dat_rd = host_rd & ~host_sel;
  assign cpu_dat_rd  = cpu_rd  & ~cpu_sel;
  assign cpu_dat_wr  = cpu_wr  & ~cpu_sel;
  assign cpu_stat_wr = cpu_wr  &  cpu_sel;

  kbc_buf #(.W(DW)) u_ibuf (
    .clk(clk), .rst(rst), .ld(host_wr), .d(host_wdata), .q(ibuf_q)
  );

  kbc_buf #(.W(DW)) u_obuf (
    .clk(clk), .rst(rst), .ld(cpu_dat_wr), .d(cpu_wdata), .q(obuf_q)
  );

  kbc_buf #(.W(1)) u_cd (
    .clk(clk), .rst(rst), .ld(host_wr), .d(host_sel), .q(cd_q)
  );

  kbc_flag u_obf (
    .clk(clk), .rst(rst), .set(cpu_dat_wr), .clr(host_dat_rd),
    .q(obf_q), .nxt(obf_nx)
  );

  kbc_flag u_ibf (
    .clk(clk), .rst(rst), .set(host_wr), .clr(cpu_dat_rd),
    .q(ibf_q), .nxt(ibf_nx)
  );

  // Status byte: flags at fixed positions, remaining bits CPU-owned
  for (genvar i = 0; i < DW; i++) begin : g_stat
    if (i == OBF_BIT) begin : g_obf
      assign status[i] = obf_q;
    end else if (i == IBF_BIT) begin : g_ibf
      assign status[i] = ibf_q;
    end else if (i == CD_BIT) begin : g_cd
      assign status[i] = cd_q[0];
    end else begin : g_user
      logic ub_q;
      always_ff @(posedge clk) begin
        if (rst)              ub_q <= 1'b0;
        else if (cpu_stat_wr) ub_q <= cpu_wdata[i] & UMASK[i];
      end
      assign status[i] = ub_q;
    end
  end

  // Registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
      cpu_rdata  <= '0;
      kirq       <= 1'b0;
      ibf_irq    <= 1'b0;
    end else begin
      if (host_rd) host_rdata <= host_sel ? status : obuf_q;
      if (cpu_rd)  cpu_rdata  <= cpu_sel  ? status : ibuf_q;
      kirq    <= obf_nx & kirq_en;
      ibf_irq <= ibf_nx;
    end
  end
endmodule

// File: rtl/kbc_mailbox_chk.sv
module kbc_mailbox_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          host_wr,
  input logic          host_rd,
  input logic          host_sel,
  input logic [DW-1:0] host_rdata,
  input logic          kirq,
  input logic          kirq_en,
  input logic          cpu_wr,
  input logic          cpu_rd,
  input logic          cpu_sel,
  input logic          ibf_irq,
  input logic [DW-1:0] status
);
  import kbc_pkg::*;
  localparam logic [DW-1:0] UM = DW'(user_mask(DW));

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (status == '0 && !kirq && !ibf_irq)); // R1
  AST_HOST_WR_SETS_IBF: assert property (@(posedge clk) disable iff (rst)
    host_wr |=> ibf_irq); // R2
  AST_CD_FOLLOWS_SEL: assert property (@(posedge clk) disable iff (rst)
    host_wr |=> status[CD_BIT] == $past(host_sel)); // R3
  AST_CPU_RD_CLEARS_IBF: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && !cpu_sel && !host_wr) |=> !ibf_irq); // R4
  AST_CPU_WR_RAISES_KIRQ: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && !cpu_sel && kirq_en) |=> kirq); // R5
  AST_KIRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    !kirq_en |=> !kirq); // R6
  AST_HOST_RD_CLEARS_KIRQ: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !host_sel && !(cpu_wr && !cpu_sel)) |=> !kirq); // R7
  AST_HOST_STATUS_READ: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_sel) |=> host_rdata == $past(status)); // R8
  AST_USER_BITS_HELD: assert property (@(posedge clk) disable iff (rst)
    !(cpu_wr && cpu_sel) |=> $stable(status & UM)); // R9
  AST_IBF_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (host_wr && cpu_rd && !cpu_sel) |=> ibf_irq); // R10
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> $stable(host_rdata)); // R11
endmodule

bind kbc_mailbox kbc_mailbox_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
  .host_sel(host_sel), .host_rdata(host_rdata), .kirq(kirq),
  .kirq_en(kirq_en), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_sel(cpu_sel),
  .ibf_irq(ibf_irq), .status(status)
);

// File: tb/kbc_mailbox_bench.sv
module kbc_mailbox_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_wr = 0, host_rd = 0, host_sel = 0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic kirq, kirq_en = 0;
  logic cpu_wr = 0, cpu_rd = 0, cpu_sel = 0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic ibf_irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  kbc_mailbox #(.DW(8)) u_kbc_mailbox (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .kirq(kirq), .kirq_en(kirq_en), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .ibf_irq(ibf_irq)
  );

  // Vector: host nibble {wr,rd,sel,0}, host data, cpu nibble {wr,rd,sel,kirq_en},
  // cpu data, expected host_rdata, expected cpu_rdata, expected nibble {kirq,ibf_irq,0,0}
  localparam int NV = 26;
  localparam logic [43:0] VEC [NV] = '{
    44'h8_5A_0_00_00_00_4, 44'h0_00_6_00_00_02_4, 44'h0_00_4_00_00_5A_0,
    44'hA_D1_0_00_00_5A_4, 44'h6_00_0_00_0A_5A_4, 44'h0_00_4_00_0A_D1_0,
    44'h0_00_A_FF_0A_D1_0, 44'h6_00_0_00_FC_D1_0, 44'h8_33_0_00_FC_D1_4,
    44'h6_00_0_00_F6_D1_4, 44'h0_00_4_00_F6_33_0, 44'h0_00_A_00_F6_33_0,
    44'h0_00_9_A5_F6_33_8, 44'h6_00_1_00_01_33_8, 44'h4_00_1_00_A5_33_0,
    44'h0_00_8_3C_A5_33_0, 44'h6_00_0_00_01_33_0, 44'h0_00_1_00_01_33_8,
    44'h4_00_9_77_3C_33_8, 44'h4_00_1_00_77_33_0, 44'h8_99_5_00_77_33_4,
    44'h0_00_5_00_77_99_0, 44'h0_00_B_10_77_99_0, 44'hA_00_1_00_77_99_4,
    44'h6_00_1_00_1A_99_4, 44'h0_00_7_00_1A_1A_4
  };

  function automatic string tag_of(int i);
    case (i)
      0, 8:              return "R2";
      3, 9:              return "R3";
      2, 5, 10:          return "R4";
      12:                return "R5";
      15, 16, 17:        return "R6";
      14, 19:            return "R7";
      1, 4, 13, 25:      return "R8";
      6, 7, 11, 22, 23, 24: return "R9";
      default:           return "R10";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    host_wr = 0; host_rd = 0; host_sel = 0; host_wdata = '0;
    cpu_wr = 0; cpu_rd = 0; cpu_sel = 0; cpu_wdata = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    chk("R1", "host_rdata", host_rdata, 8'h00);
    chk("R1", "cpu_rdata", cpu_rdata, 8'h00);
    chk("R1", "kirq", {7'b0, kirq}, 8'h00);
    chk("R1", "ibf_irq", {7'b0, ibf_irq}, 8'h00);
    host_rd = 1; host_sel = 1;
    @(negedge clk);
    chk("R1", "status after reset", host_rdata, 8'h00);
    idle();
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [43:0] v;
      v = VEC[i];
      host_wr = v[43]; host_rd = v[42]; host_sel = v[41];
      host_wdata = v[39:32];
      cpu_wr = v[31]; cpu_rd = v[30]; cpu_sel = v[29]; kirq_en = v[28];
      cpu_wdata = v[27:20];
      @(negedge clk);
      chk(tag_of(i), $sformatf("vec %0d host_rdata", i), host_rdata, v[19:12]);
      chk(tag_of(i), $sformatf("vec %0d cpu_rdata", i), cpu_rdata, v[11:4]);
      chk(tag_of(i), $sformatf("vec %0d kirq", i), {7'b0, kirq}, {7'b0, v[3]});
      chk(tag_of(i), $sformatf("vec %0d ibf_irq", i), {7'b0, ibf_irq}, {7'b0, v[2]});
    end

    // R11: read data holds without new read strobes
    idle();
    repeat (3) @(negedge clk);
    chk("R11", "host_rdata hold", host_rdata, 8'h1A);
    chk("R11", "cpu_rdata hold", cpu_rdata, 8'h1A);

    // R1: reset in mid-operation (ibf, cd, user bit set)
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R1", "mid host_rdata", host_rdata, 8'h00);
    chk("R1", "mid cpu_rdata", cpu_rdata, 8'h00);
    chk("R1", "mid ibf_irq", {7'b0, ibf_irq}, 8'h00);
    cpu_rd = 1; cpu_sel = 1;
    @(negedge clk);
    chk("R1", "mid status", cpu_rdata, 8'h00);
    idle();
    @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule